// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block decides when the processor should break into an interrupt. Hardware and software requests share one numeric space of 31 priority levels. The upper sixteen levels belong to hardware request lines, which the requesting devices hold asserted. The lower fifteen belong to software request bits, which the block latches until the request is serviced. On every cycle the block presents the highest pending level. It raises a take strobe when that level is strictly above the current interrupt priority level held in its status register.

When the processor acknowledges a taken interrupt, the block saves the current level and access mode on a small internal stack. It then moves the current level up to the serviced level and switches to kernel mode. A return request pops the most recent saved pair back into the status register. The processor can also load the level and mode directly. Vector fetch, memory stack pushes and exception sources are outside the block.

Top module: `ipl_ctrl`

## Requirements
- R1: After reset, cur_ipl_o is 0, cur_mode_o is kernel (2'b00), sw_pend_o is all zero, and the save stack is empty.
- R2: hw_req_i bit k requests level 16+k and sw_pend_o bit k stands for level k+1. pend_lvl_o is the highest-numbered active request, or 0 when none is active.
- R3: take_o is high exactly when pend_lvl_o is strictly greater than cur_ipl_o and the save stack holds fewer than STACK_DEPTH entries.
- R4: A one on sw_set_i bit k sets sw_pend_o bit k at the next clock edge. The bit stays set until its level is acknowledged.
- R5: ack_i while take_o is high is accepted. One cycle later cur_ipl_o equals the pend_lvl_o seen at the acknowledge and cur_mode_o is kernel. The previous level and mode are pushed onto the save stack.
- R6: An accepted acknowledge of a software level clears that level's sw_pend_o bit, unless the same bit is set again in that cycle. Hardware lines and other bits are unaffected.
- R7: ack_i while take_o is low changes nothing.
- R8: rei_i, with a non-empty stack and no accepted acknowledge in the same cycle, restores the most recently saved level and mode on the next cycle. rei_i with an empty stack is ignored.
- R9: st_wr_i loads st_ipl_i and st_mode_i into the status register on the next cycle, unless an acknowledge is accepted or a return is carried out in the same cycle. Mode codes are kernel 0, executive 1, supervisor 2 and user 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 16 | Level-sensitive hardware requests, bit k = level 16+k |
| sw_set_i | input | 15 | Software request set pulses, bit k = level k+1 |
| ack_i | input | 1 | Processor takes the presented interrupt |
| rei_i | input | 1 | Return from interrupt, restore saved context |
| st_wr_i | input | 1 | Direct write of level and mode |
| st_ipl_i | input | 5 | Level value for direct write |
| st_mode_i | input | 2 | Mode value for direct write |
| pend_lvl_o | output | 5 | Highest pending level, 0 if none |
| take_o | output | 1 | Pending level exceeds current level and stack has room |
| cur_ipl_o | output | 5 | Current interrupt priority level |
| cur_mode_o | output | 2 | Current access mode |
| sw_pend_o | output | 15 | Latched software requests |

## Verification
A wrong latched software bit shows on sw_pend_o one cycle after the faulty edge. It also shows on pend_lvl_o and take_o in the same cycle whenever no higher request masks it. A corrupted save-stack entry stays hidden until the matching return, which can be many cycles later. For that reason the bench nests acknowledges and returns often and compares every restored level and mode. A stale stack count shows up as take_o dropping early or staying high at depth, and as returns that are ignored or carried out wrongly.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  typedef enum logic [1:0] {
    MODE_KERNEL = 2'd0,
    MODE_EXEC   = 2'd1,
    MODE_SUPER  = 2'd2,
    MODE_USER   = 2'd3
  } mode_e;
endpackage

// File: rtl/ipl_prio_enc.sv
module ipl_prio_enc #(
  parameter int N     = 31,
  parameter int LVL_W = 5
) (
  input  logic [N-1:0]     req_i,
  output logic [LVL_W-1:0] lvl_o
);
  // bit i stands for level i+1; highest index wins
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++)
      if (req_i[i]) lvl_o = LVL_W'(i + 1);
  end

  always_comb begin
    if (lvl_o != '0)
      a_r2_winner_active: assert (req_i[lvl_o - 1'b1]);
    else
      a_r2_none_active: assert (req_i == '0);
  end
endmodule

// File: rtl/ipl_sw_pend.sv
module ipl_sw_pend #(
  parameter int N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign pend_o[g] = q;

    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !pend_o[g]);
    a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);
  end
endmodule

// File: rtl/ipl_save_stack.sv
module ipl_save_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[cnt_q - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[cnt_q] <= din_i;
      cnt_q        <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r3_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
  import ipl_pkg::*;
#(
  parameter int HW_LINES    = 16,
  parameter int SW_LEVELS   = 15,
  parameter int STACK_DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HW_LINES-1:0]  hw_req_i,
  input  logic [SW_LEVELS-1:0] sw_set_i,
  input  logic                 ack_i,
  input  logic                 rei_i,
  input  logic                 st_wr_i,
  input  logic [4:0]           st_ipl_i,
  input  logic [1:0]           st_mode_i,
  output logic [4:0]           pend_lvl_o,
  output logic                 take_o,
  output logic [4:0]           cur_ipl_o,
  output logic [1:0]           cur_mode_o,
  output logic [SW_LEVELS-1:0] sw_pend_o
);
  localparam int NLVL  = HW_LINES + SW_LEVELS;
  localparam int LVL_W = $clog2(NLVL + 1);
  localparam int CTX_W = LVL_W + 2;

  logic [LVL_W-1:0]     ipl_q;
  mode_e                mode_q;
  logic [SW_LEVELS-1:0] sw_clr;
  logic [NLVL-1:0]      req_all;
  logic [LVL_W-1:0]     pend_lvl;
  logic [CTX_W-1:0]     top_ctx;
  logic                 stk_empty, stk_full;
  logic                 acc, ret, wr;

  assign req_all = {hw_req_i, sw_pend_o};

  ipl_prio_enc #(.N(NLVL), .LVL_W(LVL_W)) i_enc (
    .req_i (req_all),
    .lvl_o (pend_lvl)
  );

  assign take_o = (pend_lvl > ipl_q) && !stk_full;
  assign acc    = ack_i && take_o;
  assign ret    = rei_i && !acc && !stk_empty;
  assign wr     = st_wr_i && !acc && !ret;

  always_comb begin
    sw_clr = '0;
    if (acc && pend_lvl != '0 && pend_lvl <= LVL_W'(SW_LEVELS))
      sw_clr[pend_lvl - 1'b1] = 1'b1;
  end

  ipl_sw_pend #(.N(SW_LEVELS)) i_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sw_set_i),
    .clr_i  (sw_clr),
    .pend_o (sw_pend_o)
  );

  ipl_save_stack #(.DEPTH(STACK_DEPTH), .W(CTX_W)) i_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc),
    .pop_i   (ret),
    .din_i   ({mode_q, ipl_q}),
    .top_o   (top_ctx),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_q  <= '0;
      mode_q <= MODE_KERNEL;
    end else if (acc) begin
      ipl_q  <= pend_lvl;
      mode_q <= MODE_KERNEL;
    end else if (ret) begin
      ipl_q  <= top_ctx[LVL_W-1:0];
      mode_q <= mode_e'(top_ctx[CTX_W-1 -: 2]);
    end else if (wr) begin
      ipl_q  <= st_ipl_i[LVL_W-1:0];
      mode_q <= mode_e'(st_mode_i);
    end
  end

  assign pend_lvl_o = 5'(pend_lvl);
  assign cur_ipl_o  = 5'(ipl_q);
  assign cur_mode_o = mode_q;

  a_r5_ack_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && take_o |=> cur_ipl_o == $past(pend_lvl_o) && cur_mode_o == MODE_KERNEL);
  a_r5_ack_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && take_o |=> cur_ipl_o > $past(cur_ipl_o));
  a_r7_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !take_o && !rei_i && !st_wr_i |=> $stable(cur_ipl_o) && $stable(cur_mode_o));
  a_r8_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret |=> {cur_mode_o, cur_ipl_o} == $past({top_ctx[CTX_W-1 -: 2], 5'(top_ctx[LVL_W-1:0])}));
endmodule

// File: tb/test_ipl_ctrl.sv
`timescale 1ns/1ps
module test_ipl_ctrl;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_req = '0;
  logic [14:0] sw_set = '0;
  logic        ack = 1'b0, rei = 1'b0, st_wr = 1'b0;
  logic [4:0]  st_ipl = '0;
  logic [1:0]  st_mode = '0;
  logic [4:0]  pend_lvl, cur_ipl;
  logic        take;
  logic [1:0]  cur_mode;
  logic [14:0] sw_pend;

  int checks = 0, fails = 0;

  logic [4:0]  m_ipl;
  logic [1:0]  m_mode;
  logic [14:0] m_sw;
  logic [4:0]  s_ipl [DEPTH];
  logic [1:0]  s_mode [DEPTH];
  int          m_sp;
  string       st_tag, sw_tag;

  always #2.5 clk = ~clk;

  ipl_ctrl #(.STACK_DEPTH(DEPTH)) i_ipl_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .sw_set_i(sw_set),
    .ack_i(ack), .rei_i(rei), .st_wr_i(st_wr), .st_ipl_i(st_ipl),
    .st_mode_i(st_mode), .pend_lvl_o(pend_lvl), .take_o(take),
    .cur_ipl_o(cur_ipl), .cur_mode_o(cur_mode), .sw_pend_o(sw_pend)
  );

  function automatic logic [4:0] exp_pend(logic [15:0] h, logic [14:0] s);
    logic [4:0] r = '0;
    for (int i = 0; i < 15; i++) if (s[i]) r = 5'(i + 1);
    for (int i = 0; i < 16; i++) if (h[i]) r = 5'(i + 16);
    return r;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ipl = '0; m_mode = '0; m_sw = '0; m_sp = 0;
    st_tag = "R1"; sw_tag = "R1";
  endtask

  // drive at negedge, compare after settle, then advance model for the coming edge
  task automatic cyc(logic [15:0] h, logic [14:0] s, logic a, logic r,
                     logic w, logic [4:0] wi, logic [1:0] wm);
    logic [4:0] ep;
    logic       et, acc, ret;
    @(negedge clk);
    hw_req = h; sw_set = s; ack = a; rei = r; st_wr = w; st_ipl = wi; st_mode = wm;
    #1;
    ep = exp_pend(h, m_sw);
    et = (ep > m_ipl) && (m_sp < DEPTH);
    chk("R2", "pend_lvl", pend_lvl, ep);
    chk("R3", "take", take, et);
    chk(st_tag, "cur_ipl", cur_ipl, m_ipl);
    chk(st_tag, "cur_mode", cur_mode, m_mode);
    chk(sw_tag, "sw_pend", sw_pend, m_sw);
    acc = a && et;
    ret = r && !acc && (m_sp > 0);
    sw_tag = "R4";
    if (acc && ep >= 1 && ep <= 15) begin
      m_sw[ep-1] = 1'b0;
      sw_tag = "R6";
    end
    m_sw = m_sw | s;
    if (acc) begin
      s_ipl[m_sp] = m_ipl; s_mode[m_sp] = m_mode; m_sp++;
      m_ipl = ep; m_mode = 2'd0; st_tag = "R5";
    end else if (ret) begin
      m_sp--; m_ipl = s_ipl[m_sp]; m_mode = s_mode[m_sp]; st_tag = "R8";
    end else if (w) begin
      m_ipl = wi; m_mode = wm; st_tag = "R9";
    end else if (a) st_tag = "R7";
    else if (r) st_tag = "R8";
    else st_tag = "R5";
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "cur_ipl in reset", cur_ipl, 0);
    chk("R1", "take in reset", take, 0);
    @(negedge clk); rst_n = 1'b1;

    // equal level is not taken; ack then ignored (R7)
    cyc('0, '0, 0, 0, 1, 5'd16, 2'd3);
    cyc(16'h0001, '0, 1, 0, 0, 0, 0);
    cyc(16'h0001, '0, 0, 0, 0, 0, 0);
    // level 17 above 16 is taken (R3, R5)
    cyc(16'h0002, '0, 1, 0, 0, 0, 0);
    cyc(16'h0002, '0, 0, 1, 0, 0, 0);   // return restores 16/user (R8)
    cyc('0, '0, 0, 1, 0, 0, 0);         // empty stack return ignored (R8)
    cyc('0, '0, 0, 0, 0, 0, 0);
    // software levels 15 and 3, ack clears only level 15 (R6)
    cyc('0, '0, 0, 0, 1, 5'd0, 2'd3);
    cyc('0, 15'h4004, 0, 0, 0, 0, 0);
    cyc('0, '0, 1, 0, 0, 0, 0);
    cyc('0, '0, 0, 0, 0, 0, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    // fill save stack: take must drop at depth (R3)
    cyc('0, '0, 0, 0, 1, 5'd0, 2'd1);
    for (int i = 0; i <= DEPTH; i++) cyc(16'(1 << i), '0, 1, 0, 0, 0, 0);
    cyc(16'h8000, '0, 1, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 1; i++) cyc('0, '0, 0, 1, 0, 0, 0);
    // ack and set same software bit in one cycle: set wins (R6)
    cyc('0, 15'h0001, 0, 0, 1, 5'd0, 2'd0);
    cyc('0, 15'h0001, 1, 0, 0, 0, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] h = '0;
      logic [14:0] s = '0;
      for (int b = 0; b < 16; b++) if ($urandom_range(0, 19) == 0) h[b] = 1'b1;
      for (int b = 0; b < 15; b++) if ($urandom_range(0, 24) == 0) s[b] = 1'b1;
      cyc(h, s, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 9) == 0, 5'($urandom_range(0, 31)),
          2'($urandom_range(0, 3)));
    end
    cyc('0, '0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule